// File: doc/BRIEF.md
# Multi-Window Address Decoder

This block sits between a host access port and a set of device regions. Each region is described by a window, typically produced by an assigned base address register: a base, a size, a space type (memory or I/O) and a priority key built from the owning device's bus and device numbers. Every access request carries an address, a space type, a size code and write data. The block compares the address with all windows in parallel and keeps only the windows whose type matches the access. Among the windows that hit, it picks the one with the lowest key.

The decode result is registered. One cycle after a request is accepted, the block does one of two things. On a hit, it presents the access to the selected region with the offset inside the window, and holds it there until that region acknowledges. On a miss, it issues a one-cycle miss response that carries zero read data.

I/O addresses arrive in the host's address map. The block subtracts a fixed I/O aperture base from them before comparing. A region may answer with an error flag, for example for an offset it does not implement. The access still completes, and the flag is passed back with the response.

Top module: `addr_window_decoder`

## Requirements
- R1: A window hits when base <= address < base + size, computed without wrap. The offset presented on `rgn_offset` is the address minus that window's base.
- R2: A memory access (`req_is_io`=0) matches only windows with `win_is_io` bit 0. An I/O access (`req_is_io`=1) matches only windows with `win_is_io` bit 1.
- R3: A window whose size is zero never hits, whatever its base.
- R4: For an I/O access, the address is first reduced by the parameter `IO_BASE` (modulo 2^AW). Window compare and offset both use the reduced address.
- R5: When several windows hit, the one with the smallest key wins. The key of window w is `win_key[w*KW +: KW]` = {bus[BUS_W-1:0], device[DEV_W-1:0]}. On equal keys, the lower window index wins. `rgn_sel` is one-hot on the winner.
- R6: Decode takes one cycle. After the clock edge that accepts a request, either `rgn_valid` is high with `rgn_sel`, `rgn_offset`, `rgn_write`, `rgn_size` and `rgn_wdata` set, or the miss response is given.
- R7: A request that hits no window gives, in the cycle after acceptance, `rsp_valid`=1 and `rsp_miss`=1 for one cycle. `rsp_rdata`=0 and `rsp_err`=0 for both reads and writes. No region is started.
- R8: A region access stays presented, unchanged, until the selected region raises its bit of `rgn_ack`. In that cycle, `rsp_valid`=1 and `rsp_miss`=0. For a read, `rsp_rdata` is that region's slice of `rgn_rdata`. For a write, `rsp_rdata` is 0.
- R9: `rsp_err` equals the selected region's `rgn_err` bit in its acknowledge cycle. The access completes either way.
- R10: `req_ready` is low while a region access is outstanding. A request offered then is not taken: it is accepted only on the first edge at which `req_ready` is high.
- R11: After reset, `rgn_valid`=0, `rsp_valid`=0 and `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request offered |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_is_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_size | input | 2 | Access size code, passed through |
| req_addr | input | AW | Access address (host map) |
| req_wdata | input | DW | Write data |
| win_base | input | NWIN*AW | Window bases, window w at [w*AW +: AW] |
| win_size | input | NWIN*AW | Window sizes in bytes |
| win_is_io | input | NWIN | Window space type bit |
| win_key | input | NWIN*KW | Window priority keys {bus, device} |
| rgn_valid | output | 1 | Region access presented |
| rgn_sel | output | NWIN | One-hot selected region |
| rgn_write | output | 1 | Region access is a write |
| rgn_size | output | 2 | Region access size code |
| rgn_offset | output | AW | Offset inside the window |
| rgn_wdata | output | DW | Region write data |
| rgn_ack | input | NWIN | Per-region acknowledge |
| rgn_err | input | NWIN | Per-region error flag, valid with acknowledge |
| rgn_rdata | input | NWIN*DW | Per-region read data |
| rsp_valid | output | 1 | Response to the host |
| rsp_miss | output | 1 | Response is a decode miss |
| rsp_err | output | 1 | Region reported an error |
| rsp_rdata | output | DW | Read data, zero on miss or write |

## Verification
Directed accesses probe the edges of each window. They cover the first and last byte inside and the bytes just outside, which separates a correct bound from an off-by-one. A memory window and a wider window overlap, and their keys are swapped and then tied, which shows whether selection follows the key and the tie-break rather than the index alone. Accesses are sent with the wrong space type, to a zero-size window, and through the I/O aperture, each of which must miss or translate. A request held during a slow region acknowledge shows whether requests are taken while busy. A random stream mixing hits, misses, reads, writes and acknowledge delays then runs against the per-clock reference model.

// File: rtl/awd_pkg.sv
package awd_pkg;
   typedef enum logic {
      SPACE_MEM = 1'b0,
      SPACE_IO  = 1'b1
   } space_e;
endpackage

// File: rtl/awd_win_cmp.sv
module awd_win_cmp
   import awd_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic [AW-1:0] addr,
   input  logic          acc_io,
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] size,
   input  logic          win_io,
   output logic          hit,
   output logic [AW-1:0] offset
);
   space_e          acc_sp;
   space_e          win_sp;
   logic   [AW-1:0] diff;

   assign acc_sp = space_e'(acc_io);
   assign win_sp = space_e'(win_io);
   assign diff   = addr - base;

   // addr >= base together with (addr - base) < size is the same
   // test as addr < base + size, with no carry out of AW bits
   assign hit    = (acc_sp == win_sp) && (size != '0) &&
                   (addr >= base) && (diff < size);
   assign offset = diff;
endmodule

// File: rtl/awd_pick.sv
module awd_pick #(
   parameter int NWIN = 4,
   parameter int AW   = 32,
   parameter int KW   = 13,
   parameter int IW   = 2
) (
   input  logic [NWIN-1:0]    hit,
   input  logic [NWIN*KW-1:0] key,
   input  logic [NWIN*AW-1:0] offs,
   output logic               any,
   output logic [IW-1:0]      idx,
   output logic [AW-1:0]      offset
);
   logic [KW-1:0] best_key;

   always_comb begin
      any      = 1'b0;
      idx      = '0;
      offset   = '0;
      best_key = '0;
      for (int w = 0; w < NWIN; w++) begin
         // strict compare keeps the lower index on equal keys
         if (hit[w] && (!any || key[w*KW +: KW] < best_key)) begin
            any      = 1'b1;
            idx      = IW'(w);
            best_key = key[w*KW +: KW];
            offset   = offs[w*AW +: AW];
         end
      end
   end
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder #(
   parameter int          NWIN    = 4,
   parameter int          AW      = 32,
   parameter int          DW      = 32,
   parameter int          BUS_W   = 8,
   parameter int          DEV_W   = 5,
   parameter logic [63:0] IO_BASE = 64'h0000_0000_F200_0000
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   output logic                      req_ready,
   input  logic                      req_write,
   input  logic                      req_is_io,
   input  logic [1:0]                req_size,
   input  logic [AW-1:0]             req_addr,
   input  logic [DW-1:0]             req_wdata,
   input  logic [NWIN*AW-1:0]        win_base,
   input  logic [NWIN*AW-1:0]        win_size,
   input  logic [NWIN-1:0]           win_is_io,
   input  logic [NWIN*(BUS_W+DEV_W)-1:0] win_key,
   output logic                      rgn_valid,
   output logic [NWIN-1:0]           rgn_sel,
   output logic                      rgn_write,
   output logic [1:0]                rgn_size,
   output logic [AW-1:0]             rgn_offset,
   output logic [DW-1:0]             rgn_wdata,
   input  logic [NWIN-1:0]           rgn_ack,
   input  logic [NWIN-1:0]           rgn_err,
   input  logic [NWIN*DW-1:0]        rgn_rdata,
   output logic                      rsp_valid,
   output logic                      rsp_miss,
   output logic                      rsp_err,
   output logic [DW-1:0]             rsp_rdata
);
   localparam int            KW        = BUS_W + DEV_W;
   localparam int            IW        = (NWIN > 1) ? $clog2(NWIN) : 1;
   localparam logic [AW-1:0] IO_BASE_L = IO_BASE[AW-1:0];

   initial begin
      assert (NWIN >= 2) else $error("NWIN must be at least 2");
      assert (AW >= 8 && AW <= 64) else $error("AW must lie in 8..64");
      assert (DW >= 8) else $error("DW must be at least 8");
      assert (BUS_W >= 1 && DEV_W >= 1) else $error("key fields need width");
   end

   // address seen by the comparators
   logic [AW-1:0]      eff_addr;
   logic [NWIN-1:0]    w_hit;
   logic [NWIN*AW-1:0] w_off;
   logic               any_hit;
   logic [IW-1:0]      win_idx;
   logic [AW-1:0]      win_off;
   logic               accept;

   assign eff_addr = req_is_io ? (req_addr - IO_BASE_L) : req_addr;

   for (genvar w = 0; w < NWIN; w++) begin : g_cmp
      awd_win_cmp #(.AW(AW)) u_cmp (
         .addr   (eff_addr),
         .acc_io (req_is_io),
         .base   (win_base[w*AW +: AW]),
         .size   (win_size[w*AW +: AW]),
         .win_io (win_is_io[w]),
         .hit    (w_hit[w]),
         .offset (w_off[w*AW +: AW])
      );
   end

   awd_pick #(.NWIN(NWIN), .AW(AW), .KW(KW), .IW(IW)) u_pick (
      .hit    (w_hit),
      .key    (win_key),
      .offs   (w_off),
      .any    (any_hit),
      .idx    (win_idx),
      .offset (win_off)
   );

   // registered decode and region access state
   logic          pend_q;
   logic          miss_q;
   logic [IW-1:0] idx_q;
   logic [AW-1:0] off_q;
   logic          wr_q;
   logic [1:0]    size_q;
   logic [DW-1:0] wdata_q;
   logic          cur_ack;
   logic          cur_err;
   logic [DW-1:0] cur_rdata;

   assign req_ready = !pend_q;
   assign accept    = req_valid && req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         miss_q  <= 1'b0;
         idx_q   <= '0;
         off_q   <= '0;
         wr_q    <= 1'b0;
         size_q  <= '0;
         wdata_q <= '0;
      end else begin
         miss_q <= accept && !any_hit;
         if (pend_q) begin
            if (cur_ack) pend_q <= 1'b0;
         end else if (accept && any_hit) begin
            pend_q  <= 1'b1;
            idx_q   <= win_idx;
            off_q   <= win_off;
            wr_q    <= req_write;
            size_q  <= req_size;
            wdata_q <= req_wdata;
         end
      end
   end

   for (genvar w = 0; w < NWIN; w++) begin : g_sel
      assign rgn_sel[w] = pend_q && (idx_q == IW'(w));
   end

   always_comb begin
      cur_ack   = 1'b0;
      cur_err   = 1'b0;
      cur_rdata = '0;
      for (int w = 0; w < NWIN; w++) begin
         if (idx_q == IW'(w)) begin
            cur_ack   = rgn_ack[w];
            cur_err   = rgn_err[w];
            cur_rdata = rgn_rdata[w*DW +: DW];
         end
      end
   end

   assign rgn_valid  = pend_q;
   assign rgn_write  = wr_q;
   assign rgn_size   = size_q;
   assign rgn_offset = off_q;
   assign rgn_wdata  = wdata_q;

   assign rsp_valid  = (pend_q && cur_ack) || miss_q;
   assign rsp_miss   = miss_q;
   assign rsp_err    = pend_q && cur_ack && cur_err;
   assign rsp_rdata  = (pend_q && cur_ack && !wr_q) ? cur_rdata : '0;
endmodule

// File: rtl/awd_checker.sv
module awd_checker #(
   parameter int NWIN = 4,
   parameter int AW   = 32,
   parameter int DW   = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               req_ready,
   input logic               rgn_valid,
   input logic [NWIN-1:0]    rgn_sel,
   input logic [AW-1:0]      rgn_offset,
   input logic [NWIN-1:0]    rgn_ack,
   input logic [NWIN*AW-1:0] win_size,
   input logic               rsp_valid,
   input logic               rsp_miss,
   input logic               rsp_err,
   input logic [DW-1:0]      rsp_rdata
);
   logic [AW-1:0] sel_size;

   always_comb begin
      sel_size = '0;
      for (int w = 0; w < NWIN; w++)
         if (rgn_sel[w]) sel_size = win_size[w*AW +: AW];
   end

   assert_sel_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rgn_valid |-> ($countones(rgn_sel) == 1));

   assert_idle_nosel_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !rgn_valid |-> (rgn_sel == '0));

   assert_offset_inside_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rgn_valid |-> (rgn_offset < sel_size));

   assert_decode_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (rgn_valid || (rsp_valid && rsp_miss)));

   assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_miss) |-> (rsp_rdata == '0 && !rsp_err && !rgn_valid));

   assert_hold_until_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rgn_valid && (rgn_ack & rgn_sel) == '0) |=>
         (rgn_valid && $stable(rgn_sel) && $stable(rgn_offset)));

   assert_hit_rsp_has_region_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_miss) |-> (rgn_valid && (rgn_ack & rgn_sel) != '0));

   assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rgn_valid |-> !req_ready);
endmodule

bind addr_window_decoder awd_checker #(.NWIN(NWIN), .AW(AW), .DW(DW)) u_awd_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .rgn_valid  (rgn_valid),
   .rgn_sel    (rgn_sel),
   .rgn_offset (rgn_offset),
   .rgn_ack    (rgn_ack),
   .win_size   (win_size),
   .rsp_valid  (rsp_valid),
   .rsp_miss   (rsp_miss),
   .rsp_err    (rsp_err),
   .rsp_rdata  (rsp_rdata)
);

// File: tb/addr_window_decoder_tb_top.sv
module addr_window_decoder_tb_top;
   localparam int          CLK_PERIOD = 10;
   localparam int          NW = 4;
   localparam int          KW = 13;
   localparam logic [31:0] IOB = 32'hF200_0000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic        req_valid = 1'b0, req_write = 1'b0, req_is_io = 1'b0;
   logic [1:0]  req_size = 2'd2;
   logic [31:0] req_addr = '0, req_wdata = '0;
   logic        req_ready;
   logic [NW*32-1:0] win_base, win_size;
   logic [NW-1:0]    win_is_io;
   logic [NW*KW-1:0] win_key;
   logic        rgn_valid, rgn_write;
   logic [NW-1:0] rgn_sel;
   logic [1:0]  rgn_size;
   logic [31:0] rgn_offset, rgn_wdata;
   logic [NW-1:0] rgn_ack = '0, rgn_err;
   logic [NW*32-1:0] rgn_rdata;
   logic        rsp_valid, rsp_miss, rsp_err;
   logic [31:0] rsp_rdata;

   // window configuration (bench view)
   logic [31:0] b_base [NW];
   logic [31:0] b_size [NW];
   bit          b_io   [NW];
   int          b_key  [NW];

   always_comb begin
      for (int w = 0; w < NW; w++) begin
         win_base[w*32 +: 32] = b_base[w];
         win_size[w*32 +: 32] = b_size[w];
         win_is_io[w]         = b_io[w];
         win_key[w*KW +: KW]  = b_key[w][KW-1:0];
      end
   end

   addr_window_decoder dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_is_io(req_is_io), .req_size(req_size), .req_addr(req_addr),
      .req_wdata(req_wdata),
      .win_base(win_base), .win_size(win_size), .win_is_io(win_is_io),
      .win_key(win_key),
      .rgn_valid(rgn_valid), .rgn_sel(rgn_sel), .rgn_write(rgn_write),
      .rgn_size(rgn_size), .rgn_offset(rgn_offset), .rgn_wdata(rgn_wdata),
      .rgn_ack(rgn_ack), .rgn_err(rgn_err), .rgn_rdata(rgn_rdata),
      .rsp_valid(rsp_valid), .rsp_miss(rsp_miss), .rsp_err(rsp_err),
      .rsp_rdata(rsp_rdata)
   );

   int errs = 0;
   int checks = 0;

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] region_val(input int r, input logic [31:0] off);
      return 32'hA500_0000 | (32'(r) << 16) | {16'h0, off[15:0]};
   endfunction

   // region responders
   int cfg_delay = 0;
   bit cfg_err = 1'b0;
   int rcnt = 0;
   assign rgn_err = cfg_err ? {NW{1'b1}} : '0;
   always_comb
      for (int r = 0; r < NW; r++) rgn_rdata[r*32 +: 32] = region_val(r, rgn_offset);

   always @(negedge clk) begin
      rgn_ack = (rgn_valid && rcnt == cfg_delay) ? rgn_sel : '0;
      rcnt    = rgn_valid ? rcnt + 1 : 0;
   end

   // behavioural reference
   task automatic mdl_decode(input bit io, input logic [31:0] a, output bit hit,
                             output int idx, output logic [31:0] off);
      logic [31:0] e;
      int bk;
      e   = io ? a - IOB : a;
      hit = 1'b0; idx = 0; off = '0; bk = 0;
      for (int w = 0; w < NW; w++) begin
         if (b_io[w] == io && longint'(e) >= longint'(b_base[w]) &&
             longint'(e) < longint'(b_base[w]) + longint'(b_size[w])) begin
            if (!hit || b_key[w] < bk) begin
               hit = 1'b1; idx = w; bk = b_key[w]; off = e - b_base[w];
            end
         end
      end
   endtask

   bit m_pend = 0, m_miss = 0, m_wr = 0;
   int m_idx = 0;
   logic [31:0] m_off = '0;
   bit d_hit; int d_idx; logic [31:0] d_off;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pend <= 0; m_miss <= 0;
      end else begin
         m_miss <= 0;
         if (m_pend) begin
            if (rgn_ack[m_idx]) m_pend <= 0;
         end else if (req_valid) begin
            mdl_decode(req_is_io, req_addr, d_hit, d_idx, d_off);
            if (d_hit) begin
               m_pend <= 1; m_idx <= d_idx; m_off <= d_off; m_wr <= req_write;
            end else m_miss <= 1;
         end
      end
   end

   // per-clock comparison
   always @(negedge clk) begin
      #2;
      if (rst_n) begin
         bit          ackn;
         logic [31:0] e_rd;
         logic [3:0]  e_sel;
         ackn  = m_pend && rgn_ack[m_idx];
         e_sel = m_pend ? (4'b1 << m_idx) : 4'b0;
         e_rd  = (ackn && !m_wr) ? region_val(m_idx, m_off) : 32'h0;
         check(req_ready == !m_pend, "R10 req_ready", 32'(req_ready), 32'(!m_pend));
         check(rgn_valid == m_pend, "R6 rgn_valid", 32'(rgn_valid), 32'(m_pend));
         check(rgn_sel == e_sel, "R5 rgn_sel", 32'(rgn_sel), 32'(e_sel));
         if (m_pend) begin
            check(rgn_offset == m_off, "R1 rgn_offset", rgn_offset, m_off);
            check(rgn_write == m_wr, "R6 rgn_write", 32'(rgn_write), 32'(m_wr));
         end
         check(rsp_valid == (ackn || m_miss), "R8 rsp_valid", 32'(rsp_valid),
               32'(ackn || m_miss));
         check(rsp_miss == m_miss, "R7 rsp_miss", 32'(rsp_miss), 32'(m_miss));
         check(rsp_rdata == e_rd, "R8 rsp_rdata", rsp_rdata, e_rd);
         check(rsp_err == (ackn && cfg_err), "R9 rsp_err", 32'(rsp_err),
               32'(ackn && cfg_err));
      end
   end

   task automatic access(input bit io, input bit wr, input logic [31:0] a,
                         input int dly, input bit er, output bit hit,
                         output int idx, output logic [31:0] off, output bit miss);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      cfg_delay = dly; cfg_err = er;
      req_is_io = io; req_write = wr; req_addr = a; req_wdata = a ^ 32'h5A5A_5A5A;
      req_valid = 1'b1;
      @(posedge clk); #1 req_valid = 1'b0;
      @(negedge clk); #3;
      hit = rgn_valid; off = rgn_offset; miss = rsp_valid && rsp_miss; idx = -1;
      for (int w = 0; w < NW; w++) if (rgn_sel[w]) idx = w;
      while (rgn_valid) begin @(negedge clk); #3; end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errs++;
      $display("FAIL R6 watchdog: actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      bit h, ms; int ix; logic [31:0] of;
      b_base[0] = 32'h1000_0000; b_size[0] = 32'h1000; b_io[0] = 0; b_key[0] = 5;
      b_base[1] = 32'h0000_0100; b_size[1] = 32'h40;   b_io[1] = 1; b_key[1] = 32;
      b_base[2] = 32'h1000_0800; b_size[2] = 32'h800;  b_io[2] = 0; b_key[2] = 2;
      b_base[3] = 32'h2000_0000; b_size[3] = 32'h0;    b_io[3] = 0; b_key[3] = 0;

      repeat (3) @(negedge clk);
      #3;
      check(req_ready == 1'b1, "R11 ready in reset", 32'(req_ready), 32'h1);
      check(rgn_valid == 1'b0, "R11 rgn_valid in reset", 32'(rgn_valid), 32'h0);
      check(rsp_valid == 1'b0, "R11 rsp_valid in reset", 32'(rsp_valid), 32'h0);
      @(negedge clk); rst_n = 1'b1;

      access(0, 0, 32'h1000_0010, 0, 0, h, ix, of, ms);
      check(h && ix == 0 && of == 32'h10, "R1 inside window 0", of, 32'h10);
      access(0, 0, 32'h1000_0FFF, 1, 0, h, ix, of, ms);
      check(h && ix == 2, "R5 lower key wins", 32'(ix), 32'd2);
      check(of == 32'h7FF, "R1 last byte offset", of, 32'h7FF);
      access(0, 0, 32'h1000_1000, 0, 0, h, ix, of, ms);
      check(!h && ms, "R1 base+size misses", 32'(h), 32'h0);
      access(0, 0, 32'h0FFF_FFFF, 0, 0, h, ix, of, ms);
      check(!h && ms, "R7 read below base misses", 32'(ms), 32'h1);
      access(1, 0, IOB + 32'h13F, 0, 0, h, ix, of, ms);
      check(h && ix == 1 && of == 32'h3F, "R4 io aperture removed", of, 32'h3F);
      access(0, 0, 32'h0000_0110, 0, 0, h, ix, of, ms);
      check(!h && ms, "R2 memory access skips io window", 32'(h), 32'h0);
      access(1, 0, IOB + 32'h1000_0000, 0, 0, h, ix, of, ms);
      check(!h && ms, "R2 io access skips memory window", 32'(h), 32'h0);
      access(0, 0, 32'h2000_0000, 0, 0, h, ix, of, ms);
      check(!h && ms, "R3 zero size window", 32'(h), 32'h0);
      access(0, 1, 32'h1000_0004, 3, 1, h, ix, of, ms);
      check(h && ix == 0, "R9 write with error completes", 32'(ix), 32'd0);
      access(0, 1, 32'h3000_0000, 0, 0, h, ix, of, ms);
      check(!h && ms, "R7 write miss", 32'(ms), 32'h1);
      access(1, 1, IOB + 32'h100, 0, 0, h, ix, of, ms);
      check(h && ix == 1 && of == 32'h0, "R4 io write first port", of, 32'h0);

      b_key[2] = 5;
      access(0, 0, 32'h1000_0900, 0, 0, h, ix, of, ms);
      check(h && ix == 0 && of == 32'h900, "R5 tie picks lower index", 32'(ix), 32'd0);
      b_key[2] = 6; b_key[0] = 40;
      access(0, 0, 32'h1000_0900, 2, 0, h, ix, of, ms);
      check(h && ix == 2 && of == 32'h100, "R5 key swap", 32'(ix), 32'd2);
      b_key[0] = 5; b_key[2] = 2;

      // request held while a slow region access is outstanding
      @(negedge clk);
      cfg_delay = 4; cfg_err = 0;
      req_is_io = 0; req_write = 0; req_addr = 32'h1000_0008; req_valid = 1'b1;
      @(posedge clk); #1 req_addr = 32'h1000_0020;
      @(negedge clk); #3;
      check(rgn_offset == 32'h8 && !req_ready, "R10 busy during access", rgn_offset, 32'h8);
      while (!req_ready) begin @(negedge clk); #3; end
      @(posedge clk); #1 req_valid = 1'b0;
      @(negedge clk); #3;
      check(rgn_valid && rgn_offset == 32'h20, "R10 held request taken later",
            rgn_offset, 32'h20);
      while (rgn_valid) begin @(negedge clk); #3; end

      for (int n = 0; n < 60; n++) begin
         bit io;
         logic [31:0] a;
         io = ($urandom % 3) == 0;
         a  = io ? IOB + 32'h0F0 + ($urandom % 32'h70)
                 : 32'h0FFF_FF00 + ($urandom % 32'h1200);
         access(io, 1'($urandom % 2), a, int'($urandom % 3), 1'($urandom % 2),
                h, ix, of, ms);
      end

      repeat (3) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule